// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Loader

This block holds the digital side of a two-channel, 8-bit voltage converter that is written over a parallel bus. Each channel has two registers in series. The first is an input register that a bus write fills. The second is a converter register whose value is the code that drives the analog stage. A write needs chip-select and the write strobe both low. A channel-select line picks channel A or channel B, and the byte on the data bus goes into that channel's input register.

A separate active-low load-control pin decides how the converter registers follow the input registers. Its level is taken at the end of each write. If it is low, the written channel's converter register takes the byte at once. If it is high, the write only stages the byte. Later, both converter registers take their input registers together on the next falling edge of load-control.

All pins are asynchronous to the system clock. Each pin passes through a two-stage synchroniser, and every update lands a fixed number of clocks after the pin edge that causes it. After reset, both codes read zero, and the converter registers act as if transparent until the first write. An active-low power-down pin raises a status flag and leaves every register as it was.

Top module: `dac_pair_loader`

## Requirements
- R1: A write is accepted when the synchronised write strobe rises while chip-select is low. The accepted write loads the data byte into channel A's input register when the channel-select is 0, and into channel B's when it is 1.
- R2: A write strobe rise while chip-select is high changes no input register and no output code.
- R3: An accepted write with load-control low updates only the selected channel's output code, to the written byte. The other channel's code keeps its value.
- R4: An accepted write with load-control high leaves both output codes unchanged.
- R5: Each falling edge of load-control copies both input registers into both converter registers. This happens once per edge, and nothing more happens while load-control stays low.
- R6: After reset, both input registers are zero and both output codes read zero. The codes stay zero until the first accepted write, and reset clears the power-down flag.
- R7: While power-down is low, the power-down flag is high. Entering or leaving power-down changes no register or output code.
- R8: An output code changes on the third rising clock edge after the strobe edge that causes it. That edge is either the write strobe rise or the load-control fall.
- R9: Codes are straight 8-bit binary and pass through unchanged, including the end values 0x00 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Active-low chip-select |
| wr_n | input | 1 | Active-low write strobe; the write ends on its rise |
| sel_b | input | 1 | Channel select: 0 = channel A, 1 = channel B |
| data | input | 8 | Data byte for the selected input register |
| ld_n | input | 1 | Load-control: low = immediate update, falling edge = load both |
| pd_n | input | 1 | Active-low power-down request |
| code_a | output | 8 | Channel A converter code |
| code_b | output | 8 | Channel B converter code |
| pd_flag | output | 1 | High while power-down is in effect |

## Verification
The bench builds the block with its default 8-bit data width and two synchroniser stages. With those values the update lands exactly three clocks after a strobe edge, so a directed check can see the old code one edge before the change and the new code on the change edge. The full 8-bit range lets the end codes 0x00 and 0xFF be tried directly. Random mixes of channel choice, load-control level, ignored writes and power-down toggles reach the case where load-control falls with both channels staged.

// File: rtl/dacl_pkg.sv
package dacl_pkg;
  localparam int unsigned CHANNELS = 2;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;

  // True when the select line addresses channel index idx
  function automatic logic chan_hit(input logic sel, input logic idx);
    return sel == idx;
  endfunction

  // An accepted write: strobe rising while chip-select is active (low)
  function automatic logic write_ok(input logic strobe_rise, input logic cs_level_n);
    return strobe_rise && !cs_level_n;
  endfunction

  // Next converter register value for one channel
  function automatic logic [7:0] dac_next(input logic load_all, input logic load_one,
                                          input logic [7:0] in_nxt, input logic [7:0] din,
                                          input logic [7:0] cur);
    if (load_all)      return in_nxt;
    else if (load_one) return din;
    else               return cur;
  endfunction
endpackage

// File: rtl/dacl_sync.sv
module dacl_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/dacl_edge.sv
module dacl_edge #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= sig;
  end

  assign rise = sig && !prev_q;
  assign fall = !sig && prev_q;
endmodule

// File: rtl/dacl_chan.sv
module dacl_chan #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_in,
  input  logic          load_one,
  input  logic          load_all,
  input  logic          transparent,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] in_q,
  output logic [DW-1:0] code
);
  import dacl_pkg::*;

  logic [DW-1:0] in_nxt;
  logic [DW-1:0] dac_q;
  logic [DW-1:0] dac_d;

  assign in_nxt = load_in ? din : in_q;

  always_comb begin
    if (load_all)      dac_d = in_nxt;
    else if (load_one) dac_d = din;
    else               dac_d = dac_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      in_q  <= in_nxt;
      dac_q <= dac_d;
    end
  end

  // Until the first write, the converter register passes the input register through
  assign code = transparent ? in_q : dac_q;
endmodule

// File: rtl/dac_pair_loader.sv
module dac_pair_loader #(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          sel_b,
  input  logic [DW-1:0] data,
  input  logic          ld_n,
  input  logic          pd_n,
  output logic [DW-1:0] code_a,
  output logic [DW-1:0] code_b,
  output logic          pd_flag
);
  import dacl_pkg::*;

  localparam int unsigned SW = DW + 5;
  localparam logic [SW-1:0] SYNC_RST = {5'b11110, {DW{1'b0}}};

  logic [SW-1:0] raw_v, sync_v;
  logic          pd_s, ld_s, cs_s, wr_s, sel_s;
  logic [DW-1:0] data_s;

  assign raw_v = {pd_n, ld_n, cs_n, wr_n, sel_b, data};

  dacl_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_v), .dout(sync_v)
  );

  assign {pd_s, ld_s, cs_s, wr_s, sel_s, data_s} = sync_v;

  // Named internal events
  logic wr_rise, wr_fall_unused, ld_rise_unused, ld_fall, wr_evt;

  dacl_edge #(.RST_VAL(1'b1)) u_wr_edge (
    .clk(clk), .rst_n(rst_n), .sig(wr_s), .rise(wr_rise), .fall(wr_fall_unused)
  );
  dacl_edge #(.RST_VAL(1'b1)) u_ld_edge (
    .clk(clk), .rst_n(rst_n), .sig(ld_s), .rise(ld_rise_unused), .fall(ld_fall)
  );

  assign wr_evt = write_ok(wr_rise, cs_s);

  // Transparent condition from reset until the first accepted write
  logic fresh_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fresh_q <= 1'b1;
    else if (wr_evt) fresh_q <= 1'b0;
  end

  logic [DW-1:0] in_arr   [CHANNELS];
  logic [DW-1:0] code_arr [CHANNELS];

  for (genvar c = 0; c < int'(CHANNELS); c++) begin : g_chan
    logic hit;
    assign hit = chan_hit(sel_s, 1'(c));
    dacl_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .load_in(wr_evt && hit),
      .load_one(wr_evt && hit && !ld_s),
      .load_all(ld_fall),
      .transparent(fresh_q),
      .din(data_s),
      .in_q(in_arr[c]),
      .code(code_arr[c])
    );
  end

  assign code_a  = code_arr[CH_A];
  assign code_b  = code_arr[CH_B];
  assign pd_flag = !pd_s;
endmodule

// File: rtl/dacl_chk.sv
module dacl_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_rise,
  input logic          wr_evt,
  input logic          cs_s,
  input logic          sel_s,
  input logic          ld_s,
  input logic          ld_fall,
  input logic [DW-1:0] data_s,
  input logic          fresh_q,
  input logic [DW-1:0] in_a,
  input logic [DW-1:0] in_b,
  input logic [DW-1:0] code_a,
  input logic [DW-1:0] code_b
);
  // R1
  input_capture_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !sel_s) |=> (in_a == $past(data_s)));
  // R1
  input_capture_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && sel_s) |=> (in_b == $past(data_s)));
  // R2
  cs_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && cs_s && !ld_fall) |=> ($stable(in_a) && $stable(in_b) && $stable(code_a) && $stable(code_b)));
  // R3
  auto_load_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !ld_s && !sel_s && !ld_fall) |=> (code_a == $past(data_s) && $stable(code_b)));
  // R3
  auto_load_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !ld_s && sel_s && !ld_fall) |=> (code_b == $past(data_s) && $stable(code_a)));
  // R4
  defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && ld_s && !ld_fall) |=> ($stable(code_a) && $stable(code_b)));
  // R5
  sim_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fall |=> (code_a == in_a && code_b == in_b));
  // R6
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fresh_q |-> (code_a == '0 && code_b == '0));
  // R7
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_evt && !ld_fall) |=> ($stable(code_a) && $stable(code_b)));
endmodule

bind dac_pair_loader dacl_chk #(.DW(DW)) u_dacl_chk (
  .clk(clk), .rst_n(rst_n), .wr_rise(wr_rise), .wr_evt(wr_evt), .cs_s(cs_s),
  .sel_s(sel_s), .ld_s(ld_s), .ld_fall(ld_fall), .data_s(data_s), .fresh_q(fresh_q),
  .in_a(in_arr[0]), .in_b(in_arr[1]), .code_a(code_a), .code_b(code_b)
);

// File: tb/dac_pair_loader_tb.sv
module dac_pair_loader_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_n = 1'b1, sel_b = 1'b0, ld_n = 1'b1, pd_n = 1'b1;
  logic [7:0] data = 8'h00;
  logic [7:0] code_a, code_b;
  logic       pd_flag;

  int n_chk = 0;
  int n_fail = 0;

  // Bench model
  logic [7:0] m_in  [2];
  logic [7:0] m_dac [2];
  logic       m_fresh;
  logic       cur_ld;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_pair_loader dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .sel_b(sel_b), .data(data),
    .ld_n(ld_n), .pd_n(pd_n), .code_a(code_a), .code_b(code_b), .pd_flag(pd_flag)
  );

  function automatic logic [7:0] exp_code(input int ch);
    return m_fresh ? m_in[ch] : m_dac[ch];
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_codes(input string tag);
    chk({tag, " code_a"}, code_a, exp_code(0));
    chk({tag, " code_b"}, code_b, exp_code(1));
  endtask

  task automatic set_ld(input logic v);
    if (cur_ld && !v) begin  // falling edge loads both (R5)
      m_dac[0] = m_in[0];
      m_dac[1] = m_in[1];
    end
    cur_ld = v;
    ld_n = v;
    idle(5);
  endtask

  task automatic do_write(input logic cs, input logic sel, input logic [7:0] d);
    cs_n = cs; sel_b = sel; data = d;
    idle(4);
    wr_n = 1'b0;
    idle(4);
    wr_n = 1'b1;
    idle(4);
    cs_n = 1'b1;
    idle(4);
    if (!cs) begin
      m_in[sel] = d;
      m_fresh = 1'b0;
      if (!cur_ld) m_dac[sel] = d;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    m_in[0] = 0; m_in[1] = 0; m_dac[0] = 0; m_dac[1] = 0;
    m_fresh = 1'b1; cur_ld = 1'b1;
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R6: reset state
    chk("R6 reset code_a", code_a, 8'h00);
    chk("R6 reset code_b", code_b, 8'h00);
    chk("R6 reset pd_flag", {7'b0, pd_flag}, 8'h00);

    // R5/R6: load-control fall before any write keeps zeros
    set_ld(1'b0);
    check_codes("R6 ld fall before write");
    set_ld(1'b1);

    // R2: write with chip-select high ignored, codes still zero
    do_write(1'b1, 1'b0, 8'hA5);
    check_codes("R2 cs high ignored");
    set_ld(1'b0);
    check_codes("R2 ignored write not staged");

    // R8: latency, immediate mode on channel A
    cs_n = 1'b0; sel_b = 1'b0; data = 8'h3C;
    idle(4);
    wr_n = 1'b0;
    idle(4);
    wr_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R8 before third edge", code_a, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R8 at third edge", code_a, 8'h3C);
    idle(3);
    cs_n = 1'b1;
    idle(4);
    m_in[0] = 8'h3C; m_dac[0] = 8'h3C; m_fresh = 1'b0;
    check_codes("R3 auto A");

    // R3/R9: immediate mode on B with end code
    do_write(1'b0, 1'b1, 8'hFF);
    check_codes("R3 R9 auto B FF");
    do_write(1'b0, 1'b0, 8'h00);
    check_codes("R9 auto A 00");

    // R4/R5: deferred on both channels then one load
    set_ld(1'b1);
    do_write(1'b0, 1'b0, 8'h81);
    check_codes("R4 deferred A held");
    do_write(1'b0, 1'b1, 8'h7E);
    check_codes("R4 deferred B held");
    set_ld(1'b0);
    chk("R5 sim A", code_a, 8'h81);
    chk("R5 sim B", code_b, 8'h7E);
    idle(10);
    check_codes("R5 no retrigger while low");

    // R7: power-down retains contents
    pd_n = 1'b0;
    idle(4);
    chk("R7 pd flag on", {7'b0, pd_flag}, 8'h01);
    check_codes("R7 pd retain");
    pd_n = 1'b1;
    idle(4);
    chk("R7 pd flag off", {7'b0, pd_flag}, 8'h00);
    check_codes("R7 pd exit retain");

    // Random mix
    for (int it = 0; it < 150; it++) begin
      int op;
      op = int'($urandom % 8);
      if (op <= 4) begin
        logic cs;
        cs = ($urandom % 8) == 0;
        if (($urandom % 2) != 32'(cur_ld)) set_ld(~cur_ld);
        do_write(cs, 1'($urandom % 2), 8'($urandom));
        check_codes(cs ? "R2 rand ignored" : (cur_ld ? "R4 rand deferred" : "R3 rand auto"));
      end else if (op == 5) begin
        set_ld(~cur_ld);
        check_codes("R5 rand ld toggle");
      end else begin
        pd_n = 1'b0;
        idle(4);
        chk("R7 rand pd flag", {7'b0, pd_flag}, 8'h01);
        check_codes("R7 rand pd");
        pd_n = 1'b1;
        idle(4);
      end
    end

    finish_run();
  end
endmodule